// File: doc/BRIEF.md
# Expanded-Memory Page Frame Mapper

This block translates accesses in a 64 KB memory window at segment 0xD000 into addresses in the RAM of an add-on expansion board. The window is split into four 16 KB slots, and a page register for each slot chooses which 16 KB page of board RAM that slot shows. A slot whose register is invalid is left unmapped, so accesses to it do not hit. The block raises one hit line for each slot and gives the translated physical address alongside.

Software sets the block up through an index/data register pair in the system-control I/O page, at offsets 0xE and 0xF. Three index values are used. The first moves the I/O base of the page registers or turns them off. The second reserves a region of board RAM in 64 KB units, which moves the start of expanded memory up and reduces the number of usable pages. The third enables 640 KB of conventional memory. Reading the data register reports the current setting for the selected index, and it also shows whether a board is fitted. Two strap inputs give the installed RAM: `ext_ram` means there is RAM above 512 KB, and `ram_640k` means at least 640 KB is installed.

Top module: `ems_frame_mapper`

## Requirements
- R1: After reset the port selector is 7 and all four page registers hold 0x00. The configuration register then reads 0x97 under index 0x50 with a board fitted. No slot hits, and 640 KB mode is off.
- R2: A page register sits at I/O address bits 13..0 equal to 0x208 | (selector << 4). I/O address bits 15..14 pick which of the four registers is accessed, and a register reads back the last byte written to it.
- R3: With selector 7 the page registers are not decoded. A read is not claimed, and a write leaves every page register unchanged.
- R4: A slot is mapped only when its register has bit 7 set and its bits 6..0, taken as the page number, are below the page count. A page count of 0 therefore unmaps every slot.
- R5: For a mapped slot the physical address is 0x80000 + reserve × 0x10000 + page × 0x4000 + memory address bits 13..0.
- R6: The reserve is taken from the low 5 bits of the byte written under index 0x51. It is forced to 0 when `ext_ram` is low. The page count is 48 − 4 × reserve, and it is 0 once the reserve is 12 or more.
- R7: The data register read returns a value that depends on the index:
  - index 0x50: 0x90 | selector, or 0xFF when `ext_ram` is low;
  - index 0x51: 0x60 | reserve;
  - any index that is not 0x50, 0x51 or 0x52: 0xFF.
  The index register at offset 0xE reads back its own value. A write under index 0x50 sets the selector to data bits 3..0.
- R8: A write under index 0x52 turns 640 KB mode on when the data is nonzero and `ram_640k` is high, and turns it off otherwise. In this mode the data read returns 0x80, and 0x00 when the mode is off.
- R9: Changing the reserve changes the mapping and the address of every slot at once, using the page values already stored.
- R10: `mem_hit` has at most one bit set. Bit n is set only for a memory address in segment 0xD000 whose bits 15..14 equal n, and only when slot n is mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_ram | input | 1 | Strap: board RAM exists above 512 KB |
| ram_640k | input | 1 | Strap: at least 640 KB installed |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, 0xFF when not claimed |
| io_claim | output | 1 | The block decodes the current I/O cycle |
| mem_addr | input | 20 | Memory address |
| mem_hit | output | 4 | Per-slot hit, one-hot or zero |
| phys_addr | output | PA_W | Translated board-RAM address |
| conv_640k | output | 1 | 640 KB conventional memory enabled |

## Verification
An I/O selector that drifts from its written value shows up at once, because the next read or write of a page register is claimed at the wrong address. A wrong reserve or page count changes the state of the slots, which shows up in `mem_hit` in the same cycle as the memory lookup that follows. A wrong reserve or page count can also shift `phys_addr` by a multiple of 64 KB while the slot still hits. A stale page register is exposed by reading it back, and it also shows up in the translated address. Any of these faults is visible within one access after the write that caused it.

// File: rtl/ems_frame_mapper.sv
module ems_frame_mapper #(
  parameter logic [11:0] SYS_PAGE  = 12'h00E,
  parameter logic [3:0]  FRAME_SEG = 4'hD,
  parameter int          PA_W      = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_ram,
  input  logic            ram_640k,
  input  logic            io_wr,
  input  logic            io_rd,
  input  logic [15:0]     io_addr,
  input  logic [7:0]      io_wdata,
  output logic [7:0]      io_rdata,
  output logic            io_claim,
  input  logic [19:0]     mem_addr,
  output logic [3:0]      mem_hit,
  output logic [PA_W-1:0] phys_addr,
  output logic            conv_640k
);
  localparam logic [7:0] IX_PORT = 8'h50;
  localparam logic [7:0] IX_RSV  = 8'h51;
  localparam logic [7:0] IX_640  = 8'h52;
  localparam logic [3:0] OFF     = 4'd7;
  localparam logic [13:0] PG_BASE = 14'h208;

  logic [7:0] cfg_idx;
  logic [3:0] port_idx;
  logic [4:0] rsv_base;
  logic       conv_q;
  logic [7:0] preg [4];

  logic sel_idx, sel_dat, sel_pg;
  assign sel_idx = io_addr[15:4] == SYS_PAGE && io_addr[3:0] == 4'hE;
  assign sel_dat = io_addr[15:4] == SYS_PAGE && io_addr[3:0] == 4'hF;
  assign sel_pg  = port_idx != OFF && io_addr[13:0] == (PG_BASE | {6'd0, port_idx, 4'd0});
  assign io_claim = (io_rd || io_wr) && (sel_idx || sel_dat || sel_pg);

  logic [5:0] pg_count;
  assign pg_count = (rsv_base >= 5'd12) ? 6'd0 : 6'd48 - {rsv_base[3:0], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_idx  <= 8'h00;
      port_idx <= OFF;
      rsv_base <= 5'd0;
      conv_q   <= 1'b0;
      for (int i = 0; i < 4; i++) preg[i] <= 8'h00;
    end else if (io_wr) begin
      if (sel_idx) cfg_idx <= io_wdata;
      if (sel_dat) begin
        case (cfg_idx)
          IX_PORT: port_idx <= io_wdata[3:0];
          IX_RSV:  rsv_base <= ext_ram ? io_wdata[4:0] : 5'd0;
          IX_640:  conv_q   <= (io_wdata != 8'h00) && ram_640k;
          default: ;
        endcase
      end
      if (sel_pg) preg[io_addr[15:14]] <= io_wdata;
    end
  end

  always_comb begin
    io_rdata = 8'hFF;
    if (sel_idx) io_rdata = cfg_idx;
    else if (sel_dat) begin
      case (cfg_idx)
        IX_PORT: io_rdata = ext_ram ? {4'h9, port_idx} : 8'hFF;
        IX_RSV:  io_rdata = 8'h60 | {3'd0, rsv_base};
        IX_640:  io_rdata = conv_q ? 8'h80 : 8'h00;
        default: io_rdata = 8'hFF;
      endcase
    end else if (sel_pg) io_rdata = preg[io_addr[15:14]];
  end

  logic [1:0] win;
  logic       in_frame;
  logic [3:0] win_map;
  assign win      = mem_addr[15:14];
  assign in_frame = mem_addr[19:16] == FRAME_SEG;

  for (genvar w = 0; w < 4; w++) begin : g_win
    assign win_map[w] = preg[w][7] && ({1'b0, preg[w][6:0]} < {2'b00, pg_count});
    assign mem_hit[w] = in_frame && win == w && win_map[w];
  end

  assign phys_addr = PA_W'(24'h080000) + (PA_W'(rsv_base) << 16)
                   + (PA_W'(preg[win][6:0]) << 14) + PA_W'(mem_addr[13:0]);
  assign conv_640k = conv_q;
endmodule

module ems_frame_mapper_chk #(
  parameter logic [11:0] SYS_PAGE = 12'h00E,
  parameter int          PA_W     = 22
) (
  input logic            clk,
  input logic            rst_n,
  input logic            io_wr,
  input logic [15:0]     io_addr,
  input logic [7:0]      io_wdata,
  input logic [7:0]      cfg_idx,
  input logic [3:0]      port_idx,
  input logic [19:0]     mem_addr,
  input logic [3:0]      mem_hit,
  input logic [PA_W-1:0] phys_addr,
  input logic            conv_640k,
  input logic            ram_640k
);
  assert_hit_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_hit));
  assert_hit_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_hit != 4'd0) |-> (mem_addr[19:16] == 4'hD && mem_hit[mem_addr[15:14]]));
  assert_offset_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_hit != 4'd0) |-> (phys_addr[13:0] == mem_addr[13:0] && phys_addr >= PA_W'(24'h080000)));
  assert_port_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == {SYS_PAGE, 4'hF} && cfg_idx == 8'h50) |=> port_idx == $past(io_wdata[3:0]));
  assert_640_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_640k) |-> $past(ram_640k));
endmodule

bind ems_frame_mapper ems_frame_mapper_chk #(.SYS_PAGE(SYS_PAGE), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
  .cfg_idx(cfg_idx), .port_idx(port_idx), .mem_addr(mem_addr), .mem_hit(mem_hit),
  .phys_addr(phys_addr), .conv_640k(conv_640k), .ram_640k(ram_640k));

// File: tb/tb_ems_frame_mapper.sv
`timescale 1ns/1ps
module tb_ems_frame_mapper;
  logic clk = 0, rst_n = 0, ext_ram = 1, ram_640k = 0;
  logic io_wr = 0, io_rd = 0;
  logic [15:0] io_addr = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic io_claim;
  logic [19:0] mem_addr = 0;
  logic [3:0] mem_hit;
  logic [21:0] phys_addr;
  logic conv_640k;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ems_frame_mapper dut (.*);

  // {base[4:0], win[1:0], preg[7:0], off[13:0], hit, pa[21:0]}
  localparam logic [51:0] VEC [9] = '{
    {5'd0,  2'd0, 8'h80, 14'h0000, 1'b1, 22'h080000},
    {5'd0,  2'd1, 8'h85, 14'h1234, 1'b1, 22'h095234},
    {5'd0,  2'd3, 8'hAF, 14'h3FFF, 1'b1, 22'h13FFFF},
    {5'd0,  2'd2, 8'hB0, 14'h0000, 1'b0, 22'h000000},
    {5'd2,  2'd0, 8'h81, 14'h0010, 1'b1, 22'h0A4010},
    {5'd2,  2'd1, 8'hA8, 14'h0000, 1'b0, 22'h000000},
    {5'd2,  2'd2, 8'h27, 14'h0000, 1'b0, 22'h000000},
    {5'd11, 2'd3, 8'h83, 14'h2000, 1'b1, 22'h13E000},
    {5'd12, 2'd0, 8'h80, 14'h0000, 1'b0, 22'h000000}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic c);
    @(negedge clk); io_addr = a; io_rd = 1;
    #2; d = io_rdata; c = io_claim;
    io_rd = 0;
  endtask

  task automatic cfg(input logic [7:0] ix, input logic [7:0] d);
    wr(16'h00EE, ix); wr(16'h00EF, d);
  endtask

  task automatic look(input logic [19:0] a);
    @(negedge clk); mem_addr = a; #2;
  endtask

  initial begin
    logic [7:0] d; logic c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    look(20'hD0000);
    chk(mem_hit == 4'd0, "R1 hit at reset", mem_hit, 0);
    chk(conv_640k == 1'b0, "R1 640 at reset", conv_640k, 0);
    wr(16'h00EE, 8'h50); rd(16'h00EF, d, c);
    chk(d == 8'h97, "R1 selector readback", d, 8'h97);
    // R3 disabled page registers
    rd(16'h0278, d, c);
    chk(c == 1'b0, "R3 read claimed when off", c, 0);
    wr(16'h0278, 8'h81);
    cfg(8'h50, 8'h02);
    rd(16'h0228, d, c);
    chk(d == 8'h00 && c, "R3 write while off took effect", d, 0);
    look(20'hD0000);
    chk(mem_hit == 4'd0, "R3 window mapped after ignored write", mem_hit, 0);

    // R2 R4 R5 R6 vector walk
    for (int i = 0; i < 9; i++) begin
      logic [51:0] v; logic [3:0] eh;
      v = VEC[i];
      cfg(8'h51, {3'd0, v[51:47]});
      wr({v[46:45], 14'h0228}, v[44:37]);
      rd({v[46:45], 14'h0228}, d, c);
      chk(d == v[44:37] && c, "R2 page register readback", d, v[44:37]);
      look({4'hD, v[46:45], v[36:23]});
      eh = v[22] ? (4'd1 << v[46:45]) : 4'd0;
      chk(mem_hit == eh, "R4 window mapping", mem_hit, eh);
      if (v[22]) chk(phys_addr == v[21:0], "R5 R6 physical address", phys_addr, v[21:0]);
    end

    // R9 re-evaluation on reserve change
    cfg(8'h51, 8'h00);
    wr(16'h4228, 8'h8A);
    look(20'hD4100);
    chk(mem_hit == 4'b0010 && phys_addr == 22'h0A8100, "R9 base0", phys_addr, 22'h0A8100);
    cfg(8'h51, 8'h03);
    look(20'hD4100);
    chk(mem_hit == 4'b0010 && phys_addr == 22'h0D8100, "R9 base3", phys_addr, 22'h0D8100);
    cfg(8'h51, 8'h0A);
    look(20'hD4100);
    chk(mem_hit == 4'b0000, "R9 base10 unmaps page 10", mem_hit, 0);
    // R10 outside frame
    cfg(8'h51, 8'h00);
    look(20'hC4100);
    chk(mem_hit == 4'b0000, "R10 outside frame", mem_hit, 0);
    // R6 no board RAM forces reserve 0
    ext_ram = 0;
    cfg(8'h51, 8'h05);
    rd(16'h00EF, d, c);
    chk(d == 8'h60, "R6 reserve forced 0", d, 8'h60);
    look(20'hD4100);
    chk(phys_addr == 22'h0A8100, "R6 address with forced reserve", phys_addr, 22'h0A8100);
    // R7 reads
    wr(16'h00EE, 8'h50); rd(16'h00EF, d, c);
    chk(d == 8'hFF, "R7 no board", d, 8'hFF);
    ext_ram = 1;
    cfg(8'h51, 8'h1F);
    rd(16'h00EF, d, c);
    chk(d == 8'h7F, "R7 reserve read", d, 8'h7F);
    wr(16'h00EE, 8'h53); rd(16'h00EF, d, c);
    chk(d == 8'hFF, "R7 unused index", d, 8'hFF);
    rd(16'h00EE, d, c);
    chk(d == 8'h53, "R7 index readback", d, 8'h53);
    // R2 move selector
    cfg(8'h50, 8'h05);
    rd(16'h0228, d, c);
    chk(c == 1'b0, "R2 old port still claimed", c, 0);
    wr(16'h8258, 8'h9C);
    rd(16'h8258, d, c);
    chk(d == 8'h9C && c, "R2 moved port readback", d, 8'h9C);
    // R8 640 mode
    cfg(8'h52, 8'h01);
    rd(16'h00EF, d, c);
    chk(d == 8'h00 && !conv_640k, "R8 blocked without RAM", d, 0);
    ram_640k = 1;
    cfg(8'h52, 8'h01);
    rd(16'h00EF, d, c);
    chk(d == 8'h80 && conv_640k, "R8 enabled", d, 8'h80);
    cfg(8'h52, 8'h00);
    rd(16'h00EF, d, c);
    chk(d == 8'h00 && !conv_640k, "R8 disabled", d, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule